// File: doc/BRIEF.md
# Privilege-Protected Processor Status Register

This block holds the status word of a segmented stack-machine processor. The word carries the execution mode (privileged or user), the external-interrupt enable, the user-trap enable, five general result flags and the number of the code segment that is running. Bits are numbered 0 (most significant) to 15. The block updates the word after every executed instruction. It applies explicit register writes under per-field privilege rules and captures the whole word as a stack marker when an interrupt or procedure call saves it. It also reloads the word from a saved marker on procedure exit.

A restore is checked against the current mode before it is loaded. In user mode, a saved word that would change the interrupt enable, or that would raise the mode to privileged, is not loaded. The block raises a one-cycle trap request instead. The user-trap enable is never taken from a saved word.

Two channels carry data and both use valid/ready. The outgoing marker is held stable while `mk_valid` is high and `mk_ready` is low. The incoming restore is accepted only when `rs_valid` and `rs_ready` are both high. `rs_ready` is low while an earlier marker is still waiting, so a restore cannot overtake a save. Producers must hold `rs_word` until the handshake completes. All other pins are plain strobes.

Top module: `psr_core`

## Requirements
- R1: While `rst_n` is low, the register goes to 0x8000: privileged mode, interrupts and user traps disabled, flags 0, segment 0. `mk_valid` and `trap_req` go low.
- R2: Word layout as a vector `[15:0]`: bit 15 (bit 0 in MSB-first numbering) is mode (1 = privileged); bit 14 is the external-interrupt enable; bit 13 is the user-trap enable; bits 12:8 are the result flags; bits 7:0 are the segment number. All register results appear on `status` after one clock edge.
- R3: On `wr_en`, bits 15 and 14 take `wr_word` only if the current mode is privileged. In user mode they keep their values.
- R4: On `wr_en`, the user-trap enable and the flags take `wr_word` in either mode. The segment field is not changed by a write.
- R5: On `ic_stb` without `wr_en`, each flag whose `fl_mask` bit is 1 takes the matching `fl_val` bit, and the other flags keep their values. When `wr_en` is high in the same cycle, the write sets all flags.
- R6: On `seg_ld`, the segment field takes `seg_num`.
- R7: A `save_req` loads the current word, including the segment, into the marker output and raises `mk_valid` the next cycle. A held marker stays stable until `mk_ready`. A `save_req` that arrives while a marker is held and `mk_ready` is low is dropped.
- R8: `rs_ready` equals the inverse of `mk_valid`. In a cycle where a restore is accepted, writes, flag updates and segment loads are ignored.
- R9: In privileged mode, an accepted restore loads every field from `rs_word` except the user-trap enable, which keeps its current value.
- R10: In user mode, an accepted restore whose bit 14 differs from the current bit 14 leaves the register unchanged and pulses `trap_req` high for one cycle.
- R11: In user mode, an accepted restore with bit 15 set leaves the register unchanged and pulses `trap_req`.
- R12: In user mode, a restore that passes both checks loads as in R9, and `trap_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ic_stb | input | 1 | Instruction completed; apply flag update |
| fl_val | input | 5 | New flag values |
| fl_mask | input | 5 | Per-flag update enable |
| wr_en | input | 1 | Explicit register write |
| wr_word | input | 16 | Write data, same layout as the status word |
| seg_ld | input | 1 | Load segment number |
| seg_num | input | 8 | New segment number |
| save_req | input | 1 | Capture word into marker (interrupt or call) |
| mk_valid | output | 1 | Marker word is available |
| mk_ready | input | 1 | Consumer accepts the marker |
| mk_word | output | 16 | Saved status word |
| rs_valid | input | 1 | Restore word offered (exit) |
| rs_ready | output | 1 | Restore can be accepted |
| rs_word | input | 16 | Saved word to reload |
| status | output | 16 | Current status word |
| trap_req | output | 1 | One-cycle illegal-restore trap |

## Verification
`status`, `mk_valid`, `mk_word` and `trap_req` are registered. Each is due exactly one rising edge after the inputs that cause it. `rs_ready` is combinational and valid in the same cycle. The bench drives inputs at the falling edge and checks `rs_ready` before the next rising edge. After that edge, the next falling edge compares every registered output with a behavioural model that has been advanced by one cycle. This covers privileged and user writes, masked flag updates, back-pressured markers, and each outcome of a restore.

// File: rtl/psr_pkg.sv
package psr_pkg;
  parameter int FLAG_W = 5;
  parameter int SEG_W  = 8;
  localparam int WORD_W = 3 + FLAG_W + SEG_W;

  typedef struct packed {
    logic              priv;
    logic              xie;
    logic              ute;
    logic [FLAG_W-1:0] flg;
    logic [SEG_W-1:0]  seg;
  } psw_t;

  localparam psw_t PSW_RESET = '{priv: 1'b1, xie: 1'b0, ute: 1'b0,
                                 flg: '0, seg: '0};
endpackage

// File: rtl/psr_upd.sv
module psr_upd
  import psr_pkg::*;
(
  input  psw_t              cur,
  input  logic              wr_en,
  input  psw_t              wr_w,
  input  logic              ic_stb,
  input  logic [FLAG_W-1:0] fl_val,
  input  logic [FLAG_W-1:0] fl_mask,
  input  logic              seg_ld,
  input  logic [SEG_W-1:0]  seg_num,
  output psw_t              nxt
);
  logic [FLAG_W-1:0] flg_n;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    always_comb begin
      if (wr_en)                    flg_n[i] = wr_w.flg[i];
      else if (ic_stb && fl_mask[i]) flg_n[i] = fl_val[i];
      else                          flg_n[i] = cur.flg[i];
    end
  end

  always_comb begin
    nxt      = cur;
    nxt.flg  = flg_n;
    if (wr_en) begin
      nxt.ute = wr_w.ute;
      if (cur.priv) begin
        nxt.priv = wr_w.priv;
        nxt.xie  = wr_w.xie;
      end
    end
    if (seg_ld) nxt.seg = seg_num;
  end
endmodule

// File: rtl/psr_rchk.sv
module psr_rchk
  import psr_pkg::*;
(
  input  psw_t cur,
  input  psw_t saved,
  output logic viol,
  output psw_t load
);
  always_comb begin
    viol     = !cur.priv && ((saved.xie != cur.xie) || saved.priv);
    load     = saved;
    load.ute = cur.ute;
  end
endmodule

// File: rtl/psr_marker.sv
module psr_marker
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [WORD_W-1:0] word,
  input  logic              ready,
  output logic              valid,
  output logic [WORD_W-1:0] data
);
  logic slot_free;
  assign slot_free = !valid || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (slot_free) begin
      valid <= cap;
      if (cap) data <= word;
    end
  end
endmodule

// File: rtl/psr_core.sv
module psr_core
  import psr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ic_stb,
  input  logic [FLAG_W-1:0]     fl_val,
  input  logic [FLAG_W-1:0]     fl_mask,
  input  logic                  wr_en,
  input  logic [WORD_W-1:0]     wr_word,
  input  logic                  seg_ld,
  input  logic [SEG_W-1:0]      seg_num,
  input  logic                  save_req,
  output logic                  mk_valid,
  input  logic                  mk_ready,
  output logic [WORD_W-1:0]     mk_word,
  input  logic                  rs_valid,
  output logic                  rs_ready,
  input  logic [WORD_W-1:0]     rs_word,
  output logic [WORD_W-1:0]     status,
  output logic                  trap_req
);
  psw_t psw_q, psw_upd, psw_load;
  logic rs_hs, rs_bad;

  assign rs_ready = !mk_valid;
  assign rs_hs    = rs_valid && rs_ready;
  assign status   = psw_q;

  psr_upd u_upd (
    .cur(psw_q), .wr_en(wr_en), .wr_w(psw_t'(wr_word)),
    .ic_stb(ic_stb), .fl_val(fl_val), .fl_mask(fl_mask),
    .seg_ld(seg_ld), .seg_num(seg_num), .nxt(psw_upd)
  );

  psr_rchk u_rchk (
    .cur(psw_q), .saved(psw_t'(rs_word)), .viol(rs_bad), .load(psw_load)
  );

  psr_marker u_mk (
    .clk(clk), .rst_n(rst_n), .cap(save_req), .word(psw_q),
    .ready(mk_ready), .valid(mk_valid), .data(mk_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psw_q    <= PSW_RESET;
      trap_req <= 1'b0;
    end else if (rs_hs) begin
      trap_req <= rs_bad;
      if (!rs_bad) psw_q <= psw_load;
    end else begin
      trap_req <= 1'b0;
      psw_q    <= psw_upd;
    end
  end
endmodule

// File: rtl/psr_core_chk.sv
module psr_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] status,
  input logic        trap_req,
  input logic        mk_valid,
  input logic        mk_ready,
  input logic [15:0] mk_word,
  input logic        rs_valid,
  input logic        rs_ready
);
  p_reset_word_r1: assert property (@(posedge clk)
    !rst_n |=> (status == 16'h8000) && !mk_valid && !trap_req);

  p_user_locked_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !status[15] |=> !status[15]);

  p_user_locked_xie_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !status[15] |=> $stable(status[14]));

  p_trap_no_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> status == $past(status));

  p_ute_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_ready) |=> status[13] == $past(status[13]));

  p_marker_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mk_valid && !mk_ready) |=> mk_valid && $stable(mk_word));
endmodule

bind psr_core psr_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .trap_req(trap_req),
  .mk_valid(mk_valid), .mk_ready(mk_ready), .mk_word(mk_word),
  .rs_valid(rs_valid), .rs_ready(rs_ready)
);

// File: tb/psr_core_tb.sv
module psr_core_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ic_stb, wr_en, seg_ld, save_req, mk_ready, rs_valid;
  logic [4:0] fl_val, fl_mask;
  logic [15:0] wr_word, rs_word;
  logic [7:0] seg_num;
  logic mk_valid, rs_ready, trap_req;
  logic [15:0] mk_word, status;

  int checks = 0, fails = 0;
  logic [15:0] m_psw, m_mkw;
  logic m_mkv, m_trap;

  always #2.5ns clk = ~clk;

  psr_core u_dut (.*);

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    ic_stb = 0; wr_en = 0; seg_ld = 0; save_req = 0; rs_valid = 0;
    fl_val = 0; fl_mask = 0; wr_word = 0; rs_word = 0; seg_num = 0;
  endtask

  // one clock: inputs are already driven at the falling edge
  task automatic step(string tag);
    logic [15:0] n = m_psw;
    logic nt = 0, nmkv = m_mkv, hs;
    logic [15:0] nmkw = m_mkw;
    chk(tag, "rs_ready", {15'b0, rs_ready}, {15'b0, !m_mkv});
    hs = rs_valid && !m_mkv;
    if (!m_mkv || mk_ready) begin
      nmkv = save_req;
      if (save_req) nmkw = m_psw;
    end
    if (hs) begin
      if (!m_psw[15] && (rs_word[14] != m_psw[14] || rs_word[15])) nt = 1;
      else n = {rs_word[15:14], m_psw[13], rs_word[12:0]};
    end else begin
      if (wr_en) begin
        if (m_psw[15]) n[15:14] = wr_word[15:14];
        n[13] = wr_word[13];
        n[12:8] = wr_word[12:8];
      end else if (ic_stb) begin
        n[12:8] = (n[12:8] & ~fl_mask) | (fl_val & fl_mask);
      end
      if (seg_ld) n[7:0] = seg_num;
    end
    @(posedge clk);
    @(negedge clk);
    m_psw = n; m_trap = nt; m_mkv = nmkv; m_mkw = nmkw;
    chk(tag, "status", status, m_psw);
    chk(tag, "trap_req", {15'b0, trap_req}, {15'b0, m_trap});
    chk(tag, "mk_valid", {15'b0, mk_valid}, {15'b0, m_mkv});
    if (m_mkv) chk(tag, "mk_word", mk_word, m_mkw);
    idle();
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(); mk_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_psw = 16'h8000; m_mkv = 0; m_mkw = 0; m_trap = 0;
    // R1 reset state
    chk("R1", "status", status, 16'h8000);
    chk("R1", "mk_valid", {15'b0, mk_valid}, 16'h0);
    step("R1");
    // R3 privileged write of mode/ie, R4 ute and flags (layout R2)
    wr_en = 1; wr_word = 16'hF5AA; step("R3");
    // R5 masked flag update
    ic_stb = 1; fl_val = 5'b01010; fl_mask = 5'b00111; step("R5");
    // R5 write wins over flag update
    ic_stb = 1; fl_val = 5'b11111; fl_mask = 5'b11111;
    wr_en = 1; wr_word = 16'hC300; step("R5");
    // R6 segment load, write leaves segment (R4)
    seg_ld = 1; seg_num = 8'h3C; step("R6");
    wr_en = 1; wr_word = 16'hC4FF; step("R4");
    // R7 marker capture and hold, second save dropped
    save_req = 1; step("R7");
    ic_stb = 1; fl_val = 5'b00001; fl_mask = 5'b00001; save_req = 1; step("R7");
    // R8 restore blocked while marker pending
    rs_valid = 1; rs_word = 16'h0011; step("R8");
    mk_ready = 1; step("R7");
    mk_ready = 0;
    // R9 privileged restore, ute kept; R8 updates ignored
    rs_valid = 1; rs_word = 16'h6A77; wr_en = 1; wr_word = 16'hFFFF;
    seg_ld = 1; seg_num = 8'h01; step("R9");
    // now user mode with ie=1
    wr_en = 1; wr_word = 16'hA000; step("R3");
    wr_en = 1; wr_word = 16'h8F00; step("R3");
    wr_en = 1; wr_word = 16'h2B00; step("R4");
    // R10 ie change in user mode traps
    rs_valid = 1; rs_word = 16'h0012; step("R10");
    step("R10");
    // R11 raise to privileged traps
    rs_valid = 1; rs_word = 16'hC055; step("R11");
    // R12 legal user restore
    rs_valid = 1; rs_word = 16'h4599; step("R12");
    // save in user mode carries segment
    save_req = 1; mk_ready = 1; step("R7");
    step("R7");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule